// File: doc/BRIEF.md
# Pipelined Burst SRAM Controller

This block is a synchronous static-RAM front end with its own storage array. A word is 36 bits, split into four 9-bit lanes (8 data bits and 1 parity bit each). An access begins when one of two address strobes is sampled low. One strobe is for a processor and the other is for a memory controller. The start address is latched at that edge. A 2-bit beat counter then walks a 4-word burst, and the burst wraps back to its first word. The low address bits follow either a linear or an interleaved order, picked by a static select pin. Read data passes through two register stages before it reaches the output pins. Writes are merged into the array lane by lane.

All pins except `oe_n`, `order_il` and `sleep` are sampled on the rising edge of `clk`. The read bus has no back-pressure. A read issued on edge E presents its word in the cycle that follows edge E+1, with no handshake. The requester holds `oe_n` low in that slot and must not start a write there. A sleep input blanks the outputs and freezes all state. After sleep is released, two further edges are ignored.

Top module: `sram_burst_ctl`

## Requirements
- R1: After reset, `rdata_oe` is 0 until a read has passed through both pipeline stages.
- R2: When `proc_strobe_n` is sampled low with `sel_pri_n` low and `sel_aux` high, the block latches `addr` and reads that word. On that edge `ctrl_strobe_n`, `gw_n`, `bw_n`, `lane_we_n` and `adv_n` have no effect, so nothing is written.
- R3: `ctrl_strobe_n` low starts an access only when `proc_strobe_n` is sampled high on the same edge. The write enables are sampled on that same edge: the start word is written if any lane is enabled, and read otherwise.
- R4: A read whose inputs are sampled on edge E drives `rdata` in the cycle after edge E+1.
- R5: In a cycle with no strobe and an open burst, `adv_n` low advances the beat by one and accesses the new word. `adv_n` high is a wait state that accesses the same word again. A write in that cycle needs at least one lane enabled; otherwise the cycle is a read.
- R6: With `order_il` = 0, beat k accesses the address whose two low bits are (start low bits + k) mod 4. The upper bits are unchanged. After four beats the sequence returns to the start word.
- R7: With `order_il` = 1, beat k accesses the address whose two low bits are start low bits XOR k.
- R8: `gw_n` low writes all four lanes. With `gw_n` high, lane i (bits 9i+8 down to 9i) is written only when `bw_n` is low and `lane_we_n[i]` is low. Lanes that are not written keep their contents.
- R9: `rdata_oe` is 1 only when a read word is in the output stage and `oe_n` is low. It is forced to 0 in the cycle after any edge that samples `gw_n` or a `lane_we_n` bit low, except an edge that starts a processor-strobe access.
- R10: While `sleep` is high, `rdata_oe` is 0 and the array and burst state are kept. The first two edges after `sleep` falls start no access and perform no write.
- R11: A strobe sampled low with `sel_pri_n` high or `sel_aux` low is a deselect. It issues no read and closes the burst. Later cycles with no strobe then access nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep | input | 1 | Power-down request, high active |
| order_il | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| proc_strobe_n | input | 1 | Processor-side address strobe, low active |
| ctrl_strobe_n | input | 1 | Controller-side address strobe, low active |
| adv_n | input | 1 | Burst advance, low active |
| sel_pri_n | input | 1 | Primary chip select, low active |
| sel_aux | input | 1 | Secondary chip select, high active |
| addr | input | ADDR_W | Start address |
| gw_n | input | 1 | Global write of all lanes, low active |
| bw_n | input | 1 | Byte-write qualifier, low active |
| lane_we_n | input | LANES | Per-lane write enables, low active |
| oe_n | input | 1 | Output enable, low active, not clocked |
| wdata | input | LANES*LANE_W | Write word |
| rdata | output | LANES*LANE_W | Read word from the output stage |
| rdata_oe | output | 1 | Drive enable for `rdata` (tri-state control) |

## Verification
The riskiest overlap is a processor strobe sampled on the same edge as a controller strobe, with global write and lane enables all low. The processor strobe must win: it starts a read of the new address, the write enables must be ignored, and they must not blank the output in the next slot. The bench forces this case in a directed test and also produces it in random cycles. A reference model computes every expected read word and every expected `rdata_oe` value, and after each such collision a read-back of the target word shows that it is unchanged. A second overlap is a strobe that arrives during the two-edge wake-up gap. This is also provoked, and it is judged by the same model.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;

  // Low address bits for beat k of a burst that starts at 'first'.
  function automatic beat_t beat_low(beat_t first, beat_t k, logic interleave);
    return interleave ? (first ^ k) : beat_t'(first + k);
  endfunction
endpackage

// File: rtl/sram_access_ctl.sv
module sram_access_ctl #(
  parameter int LANES    = 4,
  parameter int WAKE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep,
  input  logic             proc_strobe_n,
  input  logic             ctrl_strobe_n,
  input  logic             adv_n,
  input  logic             sel_pri_n,
  input  logic             sel_aux,
  input  logic             gw_n,
  input  logic             bw_n,
  input  logic [LANES-1:0] lane_we_n,
  input  logic             active,
  output logic             load,
  output logic             end_burst,
  output logic             step,
  output logic             do_read,
  output logic             do_write,
  output logic [LANES-1:0] wmask,
  output logic             blk_q
);
  localparam int WK_W = $clog2(WAKE_CYC + 1);

  logic [WK_W-1:0] wake_cnt;
  logic awake, sel_ok, start_p, start_c, cont, any_we;

  // Wake-up gap: the counter is reloaded while asleep and counts down after.
  always_ff @(posedge clk) begin
    if (!rst_n)        wake_cnt <= '0;
    else if (sleep)    wake_cnt <= WK_W'(WAKE_CYC);
    else if (wake_cnt != '0) wake_cnt <= wake_cnt - 1'b1;
  end

  always_comb begin
    awake   = !sleep && (wake_cnt == '0);
    sel_ok  = !sel_pri_n && sel_aux;
    wmask   = !gw_n ? {LANES{1'b1}} : (!bw_n ? ~lane_we_n : '0);
    start_p = awake && !proc_strobe_n && sel_ok;
    start_c = awake && proc_strobe_n && !ctrl_strobe_n && sel_ok;
    cont    = awake && proc_strobe_n && ctrl_strobe_n && active;
    end_burst = awake && !sel_ok && (!proc_strobe_n || !ctrl_strobe_n);
    load    = start_p || start_c;
    step    = cont && !adv_n;
    do_write = (start_c || cont) && (wmask != '0);
    do_read  = start_p || ((start_c || cont) && (wmask == '0));
    any_we  = !gw_n || (lane_we_n != {LANES{1'b1}});
  end

  // Output blanking for the cycle after write enables are sampled low.
  always_ff @(posedge clk) begin
    if (!rst_n) blk_q <= 1'b0;
    else        blk_q <= awake && !start_p && any_we;
  end
endmodule

// File: rtl/sram_burst_seq.sv
module sram_burst_seq
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              end_burst,
  input  logic              order_il,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic              active,
  output logic [ADDR_W-1:0] acc_addr
);
  logic [ADDR_W-1:0] base;
  beat_t beat, next_beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base   <= '0;
      beat   <= '0;
      active <= 1'b0;
    end else if (load) begin
      base   <= ext_addr;
      beat   <= '0;
      active <= 1'b1;
    end else if (end_burst) begin
      active <= 1'b0;
    end else if (step) begin
      beat <= next_beat;
    end
  end

  always_comb begin
    next_beat = step ? beat_t'(beat + 1'b1) : beat;
    if (load) acc_addr = ext_addr;
    else      acc_addr = {base[ADDR_W-1:BEAT_W],
                          beat_low(base[BEAT_W-1:0], next_beat, order_il)};
  end
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    we,
  input  logic [LANES-1:0]        wmask,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (we && wmask[g]) bank[addr] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rdata[g*LANE_W +: LANE_W] = bank[addr];
  end
endmodule

// File: rtl/sram_read_pipe.sv
module sram_read_pipe #(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [WORD_W-1:0] arr_q,
  output logic [WORD_W-1:0] out_q,
  output logic              out_v
);
  logic [WORD_W-1:0] s1_q;
  logic              s1_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= '0; s1_v <= 1'b0;
      out_q <= '0; out_v <= 1'b0;
    end else begin
      if (issue) s1_q <= arr_q;
      s1_v  <= issue;
      out_q <= s1_q;
      out_v <= s1_v;
    end
  end
endmodule

// File: rtl/sram_burst_ctl.sv
module sram_burst_ctl
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int LANES    = 4,
  parameter int LANE_W   = 9,
  parameter int WAKE_CYC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sleep,
  input  logic                    order_il,
  input  logic                    proc_strobe_n,
  input  logic                    ctrl_strobe_n,
  input  logic                    adv_n,
  input  logic                    sel_pri_n,
  input  logic                    sel_aux,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    gw_n,
  input  logic                    bw_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);
  localparam int WORD_W = LANES * LANE_W;

  logic              load, end_burst, step, do_read, do_write, blk_q, active, out_v;
  logic [LANES-1:0]  wmask;
  logic [ADDR_W-1:0] acc_addr;
  logic [WORD_W-1:0] arr_q;

  sram_access_ctl #(.LANES(LANES), .WAKE_CYC(WAKE_CYC)) u_ctl (
    .clk(clk), .rst_n(rst_n), .sleep(sleep),
    .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n), .adv_n(adv_n),
    .sel_pri_n(sel_pri_n), .sel_aux(sel_aux), .gw_n(gw_n), .bw_n(bw_n),
    .lane_we_n(lane_we_n), .active(active), .load(load), .end_burst(end_burst),
    .step(step), .do_read(do_read), .do_write(do_write), .wmask(wmask), .blk_q(blk_q)
  );

  sram_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .end_burst(end_burst),
    .order_il(order_il), .ext_addr(addr), .active(active), .acc_addr(acc_addr)
  );

  sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .addr(acc_addr), .we(do_write), .wmask(wmask),
    .wdata(wdata), .rdata(arr_q)
  );

  sram_read_pipe #(.WORD_W(WORD_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .issue(do_read), .arr_q(arr_q),
    .out_q(rdata), .out_v(out_v)
  );

  // Output enable is combinational in oe_n and sleep; blanking is registered.
  assign rdata_oe = out_v && !oe_n && !blk_q && !sleep;
endmodule

// File: rtl/sram_burst_ctl_chk.sv
module sram_burst_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep,
  input logic       oe_n,
  input logic       adv_n,
  input logic       proc_strobe_n,
  input logic       rdata_oe,
  input logic       load,
  input logic       step,
  input logic       end_burst,
  input logic       do_read,
  input logic       do_write,
  input logic       active,
  input logic [1:0] beat
);
  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (!rst_n)          cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 1'b1;
  end

  a_r9_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> !oe_n);
  a_r10_sleep_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rdata_oe);
  a_r10_wake_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && ($past(sleep) || $past(sleep, 2))) |-> !(do_read || do_write));
  a_r4_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && rdata_oe) |-> $past(do_read, 2));
  a_r5_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(beat));
  a_r5_step_adv: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !adv_n);
  a_r11_desel_ends: assert property (@(posedge clk) disable iff (!rst_n)
    end_burst |=> !active);
  a_r2_proc_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !proc_strobe_n |-> !do_write);
endmodule

bind sram_burst_ctl sram_burst_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .oe_n(oe_n), .adv_n(adv_n),
  .proc_strobe_n(proc_strobe_n), .rdata_oe(rdata_oe), .load(load), .step(step),
  .end_burst(end_burst), .do_read(do_read), .do_write(do_write),
  .active(active), .beat(u_seq.beat)
);

// File: tb/tb_sram_burst_ctl.sv
module tb_sram_burst_ctl;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, sleep, order_il, proc_n, ctrl_n, adv_n, sel_pri_n, sel_aux;
  logic gw_n, bw_n, oe_n;
  logic [3:0]  lane_we_n;
  logic [AW-1:0] addr;
  logic [35:0] wdata, rdata;
  logic rdata_oe;

  sram_burst_ctl dut (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .order_il(order_il),
    .proc_strobe_n(proc_n), .ctrl_strobe_n(ctrl_n), .adv_n(adv_n),
    .sel_pri_n(sel_pri_n), .sel_aux(sel_aux), .addr(addr), .gw_n(gw_n),
    .bw_n(bw_n), .lane_we_n(lane_we_n), .oe_n(oe_n), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  int checks = 0, fails = 0;
  logic [35:0] refm [DEPTH];
  logic m_active = 0;
  logic [AW-1:0] m_base = 0;
  logic [1:0] m_off = 0;
  int m_wake = 0;
  logic v1 = 0, v2 = 0;
  logic [35:0] d1 = 0, d2 = 0;

  function automatic logic [1:0] low_bits(logic [1:0] s, logic [1:0] k, logic il);
    return il ? (s ^ k) : 2'(s + k);
  endfunction

  function automatic logic [35:0] merge(logic [35:0] old, logic [35:0] nw, logic [3:0] m);
    logic [35:0] r = old;
    for (int i = 0; i < 4; i++) if (m[i]) r[i*9 +: 9] = nw[i*9 +: 9];
    return r;
  endfunction

  task automatic check(string tag, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_in();
    proc_n = 1; ctrl_n = 1; adv_n = 1; sel_pri_n = 0; sel_aux = 1;
    gw_n = 1; bw_n = 1; lane_we_n = 4'hF; oe_n = 0; sleep = 0;
  endtask

  // Reference model for one clock: computes the expected effect of the
  // current pins from the requirements, then clocks and checks the outputs.
  task automatic run(string tag);
    logic awake, selok, sp, sc, ds, ct, wr, rd, blk, oe_exp;
    logic [3:0] m;
    logic [1:0] k;
    logic [AW-1:0] a;
    awake = !sleep && m_wake == 0;
    selok = !sel_pri_n && sel_aux;
    m  = !gw_n ? 4'hF : (!bw_n ? ~lane_we_n : 4'h0);
    sp = awake && !proc_n && selok;
    sc = awake && proc_n && !ctrl_n && selok;
    ds = awake && !selok && (!proc_n || !ctrl_n);
    ct = awake && proc_n && ctrl_n && m_active;
    k  = adv_n ? m_off : 2'(m_off + 1);
    a  = (sp || sc) ? addr : {m_base[AW-1:2], low_bits(m_base[1:0], k, order_il)};
    wr = (sc || ct) && m != 0;
    rd = sp || ((sc || ct) && m == 0);
    blk = awake && !sp && (!gw_n || lane_we_n != 4'hF);
    if (sp || sc) begin m_base = addr; m_off = 0; m_active = 1; end
    else if (ds) m_active = 0;
    else if (ct && !adv_n) m_off = m_off + 1;
    if (sleep) m_wake = 2; else if (m_wake > 0) m_wake--;
    @(posedge clk);
    @(negedge clk);
    v2 = v1; d2 = d1; v1 = rd; d1 = refm[a];
    if (wr) refm[a] = merge(refm[a], wdata, m);
    oe_exp = v2 && !oe_n && !blk && !sleep;
    check({tag, " oe"}, {35'd0, rdata_oe}, {35'd0, oe_exp});
    if (oe_exp) check({tag, " data"}, rdata, d2);
  endtask

  task automatic flush(string tag);
    idle_in(); run(tag); run(tag); run(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_in(); order_il = 0; addr = 0; wdata = 0; rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    check("R1 reset oe", {35'd0, rdata_oe}, 36'd0);

    // R3/R6: fill the array with controller-strobe write bursts, linear order.
    for (int b = 0; b < DEPTH / 4; b++) begin
      idle_in(); ctrl_n = 0; gw_n = 0; addr = AW'(b * 4); wdata = {$urandom, $urandom};
      run("R3");
      for (int j = 0; j < 3; j++) begin
        idle_in(); gw_n = 0; adv_n = 0; wdata = {$urandom, $urandom};
        run("R6");
      end
    end
    // read back all of them by processor bursts
    for (int b = 0; b < DEPTH / 4; b++) begin
      idle_in(); proc_n = 0; addr = AW'(b * 4); run("R6");
      for (int j = 0; j < 4; j++) begin idle_in(); adv_n = 0; run("R6"); end
    end
    flush("R4");

    // R8: lane writes
    idle_in(); ctrl_n = 0; bw_n = 0; lane_we_n = 4'b1010; addr = 8; wdata = 36'h123456789;
    run("R8");
    idle_in(); bw_n = 1; lane_we_n = 4'b0000; adv_n = 0; wdata = 36'hFFFFFFFFF; run("R8");
    idle_in(); proc_n = 0; addr = 8; run("R8");
    idle_in(); adv_n = 0; run("R8");
    flush("R8");

    // R2: both strobes with all write enables low: read wins, no write
    idle_in(); proc_n = 0; ctrl_n = 0; gw_n = 0; bw_n = 0; lane_we_n = 0; addr = 12;
    wdata = 36'hABCDEF012; run("R2");
    idle_in(); run("R2"); run("R2");
    idle_in(); proc_n = 0; addr = 12; run("R2"); flush("R2");

    // R5: wait states then wrap
    idle_in(); proc_n = 0; addr = 17; run("R5");
    idle_in(); run("R5"); run("R5");
    for (int j = 0; j < 5; j++) begin idle_in(); adv_n = 0; run("R5"); end
    flush("R5");

    // R7: interleaved burst starting at low bits 2
    order_il = 1;
    idle_in(); proc_n = 0; addr = 22; run("R7");
    for (int j = 0; j < 4; j++) begin idle_in(); adv_n = 0; run("R7"); end
    flush("R7");
    order_il = 0;

    // R9: read with oe_n high, then write straight after a read
    idle_in(); proc_n = 0; addr = 24; oe_n = 1; run("R9");
    idle_in(); oe_n = 1; adv_n = 0; run("R9");
    idle_in(); oe_n = 1; adv_n = 0; run("R9");
    idle_in(); adv_n = 0; gw_n = 0; wdata = 36'h0F0F0F0F0; run("R9");
    flush("R9");

    // R10: sleep inside a burst, strobes during the wake-up gap
    idle_in(); proc_n = 0; addr = 28; run("R10");
    idle_in(); adv_n = 0; run("R10");
    idle_in(); sleep = 1; adv_n = 0; run("R10"); run("R10"); run("R10");
    idle_in(); ctrl_n = 0; gw_n = 0; addr = 40; wdata = 36'h555555555; run("R10");
    idle_in(); adv_n = 0; gw_n = 0; run("R10");
    idle_in(); adv_n = 0; run("R10");
    flush("R10");
    idle_in(); proc_n = 0; addr = 40; run("R10"); flush("R10");

    // R11: blocked processor strobe and deselect, then nothing is accessed
    idle_in(); proc_n = 0; addr = 30; run("R11");
    idle_in(); proc_n = 0; sel_pri_n = 1; addr = 44; run("R11");
    idle_in(); gw_n = 0; adv_n = 0; wdata = 36'h999999999; run("R11");
    idle_in(); run("R11");
    idle_in(); ctrl_n = 0; sel_aux = 0; run("R11");
    idle_in(); adv_n = 0; gw_n = 0; run("R11");
    idle_in(); proc_n = 0; addr = 30; run("R11");
    idle_in(); adv_n = 0; run("R11"); flush("R11");

    // Random mix covering all requirements through the model
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      idle_in();
      proc_n    = !(r < 12);
      ctrl_n    = !(r >= 8 && r < 22);
      sel_pri_n = ($urandom_range(0, 15) == 0);
      sel_aux   = ($urandom_range(0, 15) != 0);
      adv_n     = $urandom_range(0, 2) == 0;
      gw_n      = $urandom_range(0, 5) != 0;
      bw_n      = $urandom_range(0, 2) != 0;
      lane_we_n = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'hF;
      oe_n      = $urandom_range(0, 7) == 0;
      sleep     = $urandom_range(0, 40) == 0;
      order_il  = (i >= 1500);
      addr      = AW'($urandom);
      wdata     = {$urandom, $urandom};
      run("R5 random");
    end
    flush("R4");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule